// File: doc/BRIEF.md
# Narrow-Bus Burst Cycle Sequencer

This block sits between a core's load/store unit and a 16-bit external data bus. It handles memory writes, I/O reads and I/O writes. The core hands over a 32-bit byte address, a byte count and a transfer kind. The block then drives the data cycles that move those bytes: an address strobe, the byte address, active-low byte enables, the memory/IO, write/read and data/control qualifiers, and an active-low last-cycle flag.

The transfer is cut into pieces, one per aligned dword it touches. A piece is split by 16-bit half. If it has bytes in both halves, it runs as a two-beat burst behind a single address strobe. If it has bytes in only one half, it runs as one plain cycle. Each data beat ends when the bus pulls either the normal ready or the burst ready low. When only the normal ready answers the first beat of a burst, the upper half is finished as a separate cycle with a fresh strobe. A one-clock done pulse tells the core that the last beat has completed.

Top module: `nb_burst_seq`

## Requirements
- R1: A piece with enabled bytes in both 16-bit halves of its dword runs as a burst. It has exactly one address strobe and two data beats, with the last-cycle flag high in the first beat and low in the second.
- R2: In a burst's first beat, the byte enables are the inverse of the piece's byte mask, and address bits 1:0 name the lowest enabled byte. In the second beat, the enables are the inverse of the mask with bits 1:0 cleared, and address bits 1:0 read 2. Examples: a 4-byte piece at offset 0 gives 0000 then 0011; 3 bytes at offset 1 give 0001 then 0011; 2 bytes at offset 1 give 1001 then 1011; 3 bytes at offset 0 give 1000 at offset 0, then 1011 at offset 2.
- R3: A piece whose bytes lie in one half only runs as a single cycle. It has one strobe, the last-cycle flag low, byte enables equal to the inverse mask, and address bits 1:0 at the lowest enabled byte.
- R4: Address bits 31:2 and the qualifiers do not change during a burst. Encoding: kind 0 is a memory write (mio_o=1, wr_o=1), kind 1 is an I/O read (mio_o=0, wr_o=0), kind 2 is an I/O write (mio_o=0, wr_o=1), and dc_o is always 1.
- R5: A transfer that spans several dwords is issued as consecutive per-dword pieces in rising address order. Each piece opens with its own address strobe, and a piece starts only after the previous piece's final ready. The address carry into bit 4 and above follows the arithmetic.
- R6: ads_no_o is low for exactly one clock per cycle. A data beat ends at the first clock where rdy_ni or brdy_ni is low. While both are high, the address and byte enables hold and no strobe is issued.
- R7: If the first beat of a burst is ended by rdy_ni alone, the upper-half bytes are sent as a separate cycle: a new strobe, the same enables and address as a second burst beat, and the last-cycle flag low.
- R8: ack_o is high only while the block is idle and req_i is high. A request made while a transfer is running is not acknowledged and does not change the running transfer.
- R9: done_o is high for exactly one clock, the clock after the final ready of a transfer. A request with length 0 is acknowledged and gives done_o on the next clock with no bus cycle.
- R10: After reset, ads_no_o and blast_no_o are high, be_no_o is 1111, and done_o and ack_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request from the core |
| addr_i | input | 32 | Starting byte address |
| len_i | input | 4 | Byte count (0 to 15) |
| kind_i | input | 2 | Transfer kind: 0 memory write, 1 I/O read, 2 I/O write |
| ack_o | output | 1 | Request accepted this clock |
| done_o | output | 1 | One-clock pulse after the final data beat |
| rdy_ni | input | 1 | Normal ready, active low |
| brdy_ni | input | 1 | Burst ready, active low |
| ads_no | output | 1 | Address strobe, active low |
| addr_o | output | 32 | Byte address of the current beat |
| be_no_o | output | 4 | Byte enables, active low |
| blast_no_o | output | 1 | Last-cycle flag, active low |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| wr_o | output | 1 | 1 = write, 0 = read |
| dc_o | output | 1 | 1 = data, 0 = control |

## Verification
A corrupted piece pointer or remaining count shows up at the next address strobe. It appears as a wrong address nibble, a wrong byte mask, or a wrong number of strobes before done_o. A wrong beat index or burst decision shows up within one beat, through the byte enables or the last-cycle flag. A stray transition between the strobe and data phases becomes visible at once as an extra or missing strobe, or as lost ready handling. Every case is checked on the strobe and beat pattern of each transfer and on the cycle that carries done_o.

// File: rtl/nb_burst_seq_pkg.sv
package nb_burst_seq_pkg;
  localparam int unsigned DW_BYTES = 4;

  typedef enum logic [1:0] {
    KIND_MEM_WR = 2'd0,
    KIND_IO_RD  = 2'd1,
    KIND_IO_WR  = 2'd2
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nbs_piece_plan.sv
module nbs_piece_plan #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [LEN_W-1:0]  remain_i,
  output logic [3:0]        mask_o,
  output logic              last_piece_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic [LEN_W-1:0]  next_remain_o
);
  localparam int unsigned OFF_W = 2;

  logic [OFF_W-1:0] off;
  logic [2:0]       room;
  logic [2:0]       nbytes;

  always_comb begin
    off    = cur_addr_i[OFF_W-1:0];
    room   = 3'd4 - {1'b0, off};
    nbytes = (remain_i < LEN_W'(room)) ? remain_i[2:0] : room;
    for (int i = 0; i < 4; i++) begin
      mask_o[i] = (i >= int'(off)) && (i < int'(off) + int'(nbytes));
    end
    last_piece_o  = (remain_i == LEN_W'(nbytes));
    next_remain_o = remain_i - LEN_W'(nbytes);
    next_addr_o   = {cur_addr_i[ADDR_W-1:OFF_W] + 1'b1, {OFF_W{1'b0}}};
  end
endmodule

// File: rtl/nbs_beat_enc.sv
module nbs_beat_enc (
  input  logic [3:0] mask_i,
  input  logic       beat_hi_i,
  output logic [3:0] be_n_o,
  output logic [1:0] lo_addr_o,
  output logic       blast_n_o,
  output logic       burstable_o
);
  always_comb begin
    burstable_o = (|mask_i[1:0]) && (|mask_i[3:2]);
    if (beat_hi_i) begin
      be_n_o    = ~(mask_i & 4'b1100);
      lo_addr_o = 2'd2;
      blast_n_o = 1'b0;
    end else begin
      be_n_o    = ~mask_i;
      blast_n_o = burstable_o;
      lo_addr_o = 2'd0;
      for (int i = 3; i >= 0; i--) begin
        if (mask_i[i]) lo_addr_o = 2'(i);
      end
    end
  end
endmodule

// File: rtl/nbs_seq_ctrl.sv
module nbs_seq_ctrl
  import nb_burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        kind_i,
  input  logic              rdy_ni,
  input  logic              brdy_ni,
  input  logic              burstable_i,
  input  logic              last_piece_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic [LEN_W-1:0]  next_remain_i,
  output logic              idle_o,
  output logic              addr_ph_o,
  output logic              data_ph_o,
  output logic              beat_hi_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic [1:0]        kind_o,
  output logic              done_o
);
  seq_state_e state_q;
  logic       beat_hi_q;
  logic       done_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [LEN_W-1:0]  remain_q;
  logic [1:0]        kind_q;
  logic              beat_end;

  assign beat_end = !rdy_ni || !brdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      beat_hi_q  <= 1'b0;
      done_q     <= 1'b0;
      cur_addr_q <= '0;
      remain_q   <= '0;
      kind_q     <= 2'd0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              cur_addr_q <= addr_i;
              remain_q   <= len_i;
              kind_q     <= kind_i;
              beat_hi_q  <= 1'b0;
              state_q    <= ST_ADDR;
            end
          end
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          if (beat_end) begin
            if (burstable_i && !beat_hi_q) begin
              // burst ready keeps the burst; normal ready forces a new cycle
              beat_hi_q <= 1'b1;
              state_q   <= !brdy_ni ? ST_DATA : ST_ADDR;
            end else begin
              beat_hi_q <= 1'b0;
              if (last_piece_i) begin
                state_q  <= ST_IDLE;
                done_q   <= 1'b1;
                remain_q <= '0;
              end else begin
                cur_addr_q <= next_addr_i;
                remain_q   <= next_remain_i;
                state_q    <= ST_ADDR;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign addr_ph_o  = (state_q == ST_ADDR);
  assign data_ph_o  = (state_q == ST_DATA);
  assign beat_hi_o  = beat_hi_q;
  assign cur_addr_o = cur_addr_q;
  assign remain_o   = remain_q;
  assign kind_o     = kind_q;
  assign done_o     = done_q;

  AST_ADDR_TO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR) |=> (state_q == ST_DATA) && $stable(cur_addr_q)); // R6
  AST_HI_NEEDS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph_o && beat_hi_q) |-> burstable_i); // R2
endmodule

// File: rtl/nb_burst_seq.sv
module nb_burst_seq
  import nb_burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        kind_i,
  output logic              ack_o,
  output logic              done_o,
  input  logic              rdy_ni,
  input  logic              brdy_ni,
  output logic              ads_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        be_no_o,
  output logic              blast_no_o,
  output logic              mio_o,
  output logic              wr_o,
  output logic              dc_o
);
  logic              idle, addr_ph, data_ph, beat_hi;
  logic [ADDR_W-1:0] cur_addr, next_addr;
  logic [LEN_W-1:0]  remain, next_remain;
  logic [1:0]        kind_q;
  logic [3:0]        mask, be_n;
  logic [1:0]        lo_addr;
  logic              blast_n, burstable, last_piece;

  nbs_piece_plan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_plan (
    .cur_addr_i    (cur_addr),
    .remain_i      (remain),
    .mask_o        (mask),
    .last_piece_o  (last_piece),
    .next_addr_o   (next_addr),
    .next_remain_o (next_remain)
  );

  nbs_beat_enc u_enc (
    .mask_i      (mask),
    .beat_hi_i   (beat_hi),
    .be_n_o      (be_n),
    .lo_addr_o   (lo_addr),
    .blast_n_o   (blast_n),
    .burstable_o (burstable)
  );

  nbs_seq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .addr_i        (addr_i),
    .len_i         (len_i),
    .kind_i        (kind_i),
    .rdy_ni        (rdy_ni),
    .brdy_ni       (brdy_ni),
    .burstable_i   (burstable),
    .last_piece_i  (last_piece),
    .next_addr_i   (next_addr),
    .next_remain_i (next_remain),
    .idle_o        (idle),
    .addr_ph_o     (addr_ph),
    .data_ph_o     (data_ph),
    .beat_hi_o     (beat_hi),
    .cur_addr_o    (cur_addr),
    .remain_o      (remain),
    .kind_o        (kind_q),
    .done_o        (done_o)
  );

  assign ack_o      = req_i && idle;
  assign ads_no     = !addr_ph;
  assign addr_o     = {cur_addr[ADDR_W-1:2], lo_addr};
  assign be_no_o    = idle ? 4'hF : be_n;
  assign blast_no_o = idle ? 1'b1 : blast_n;
  assign mio_o      = (kind_q == KIND_MEM_WR);
  assign wr_o       = (kind_q != KIND_IO_RD);
  assign dc_o       = 1'b1;

  AST_ADS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |=> ads_no); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph && rdy_ni && brdy_ni) |=> ($stable(be_no_o) && $stable(addr_o) && ads_no)); // R6
  AST_BURST_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph && blast_no_o && !brdy_ni) |=>
      (ads_no && !blast_no_o && $stable(addr_o[ADDR_W-1:2]) && $stable(mio_o) && $stable(wr_o))); // R4
  AST_SPLIT_ADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph && blast_no_o && brdy_ni && !rdy_ni) |=> (!ads_no && !blast_no_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ACK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && len_i != '0) |=> !ads_no); // R8
endmodule

// File: tb/nb_burst_seq_bench.sv
module nb_burst_seq_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [3:0]  len_i = '0;
  logic [1:0]  kind_i = '0;
  logic rdy_ni = 1'b1, brdy_ni = 1'b1;
  logic ack_o, done_o, ads_no, blast_no_o, mio_o, wr_o, dc_o;
  logic [31:0] addr_o;
  logic [3:0]  be_no_o;

  always #2 clk_i = ~clk_i;

  nb_burst_seq u_nb_burst_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .len_i(len_i),
    .kind_i(kind_i), .ack_o(ack_o), .done_o(done_o), .rdy_ni(rdy_ni), .brdy_ni(brdy_ni),
    .ads_no(ads_no), .addr_o(addr_o), .be_no_o(be_no_o), .blast_no_o(blast_no_o),
    .mio_o(mio_o), .wr_o(wr_o), .dc_o(dc_o)
  );

  typedef struct packed {
    logic [3:0] nib; logic [3:0] len; logic use_rdy;
    logic [2:0] nb; logic [2:0] na;
    logic [3:0] be0; logic [3:0] a0; logic bl0;
    logic [3:0] be1; logic [3:0] a1; logic bl1;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{4'h0, 4'd4, 1'b0, 3'd2, 3'd1, 4'b0000, 4'h0, 1'b1, 4'b0011, 4'h2, 1'b0},
    '{4'h5, 4'd3, 1'b0, 3'd2, 3'd1, 4'b0001, 4'h5, 1'b1, 4'b0011, 4'h6, 1'b0},
    '{4'h9, 4'd2, 1'b0, 3'd2, 3'd1, 4'b1001, 4'h9, 1'b1, 4'b1011, 4'hA, 1'b0},
    '{4'hC, 4'd3, 1'b0, 3'd2, 3'd1, 4'b1000, 4'hC, 1'b1, 4'b1011, 4'hE, 1'b0},
    '{4'h0, 4'd2, 1'b0, 3'd1, 3'd1, 4'b1100, 4'h0, 1'b0, 4'hF, 4'h0, 1'b0},
    '{4'h6, 4'd2, 1'b0, 3'd1, 3'd1, 4'b0011, 4'h6, 1'b0, 4'hF, 4'h0, 1'b0},
    '{4'hB, 4'd1, 1'b0, 3'd1, 3'd1, 4'b0111, 4'hB, 1'b0, 4'hF, 4'h0, 1'b0},
    '{4'h4, 4'd4, 1'b1, 3'd2, 3'd2, 4'b0000, 4'h4, 1'b1, 4'b0011, 4'h6, 1'b0},
    '{4'hD, 4'd2, 1'b1, 3'd2, 3'd2, 4'b1001, 4'hD, 1'b1, 4'b1011, 4'hE, 1'b0},
    '{4'h8, 4'd1, 1'b1, 3'd1, 3'd1, 4'b1110, 4'h8, 1'b0, 4'hF, 4'h0, 1'b0},
    '{4'h1, 4'd3, 1'b1, 3'd2, 3'd2, 4'b0001, 4'h1, 1'b1, 4'b0011, 4'h2, 1'b0}
  };
  localparam logic [31:0] BASE = 32'hA5C3_1E40;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [3:0]  ob_be [8];
  logic [31:0] ob_ad [8];
  logic        ob_bl [8];
  int nbeats, nads, qual_bad, hold_bad, busy_ack, first_ack;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] a, input logic [3:0] l, input logic [1:0] k,
                          input logic use_rdy, input int waits, input int hold_req);
    int w = waits;
    logic [3:0] hold_be = 4'h0;
    logic exp_mio = (k == 2'd0);
    logic exp_wr  = (k != 2'd1);
    nbeats = 0; nads = 0; qual_bad = 0; hold_bad = 0; busy_ack = 0;
    @(negedge clk_i);
    addr_i = a; len_i = l; kind_i = k; req_i = 1'b1;
    #1 first_ack = int'(ack_o);
    @(negedge clk_i);
    for (int it = 0; it < 64; it++) begin
      if (hold_req != 0 && it < 2) begin
        if (ack_o) busy_ack++;
      end else begin
        req_i = 1'b0;
      end
      if (done_o) break;
      if (mio_o !== exp_mio || wr_o !== exp_wr || dc_o !== 1'b1) qual_bad++;
      if (!ads_no) begin
        nads++;
        rdy_ni = 1'b1; brdy_ni = 1'b1;
      end else if (w > 0) begin
        if (w == waits) hold_be = be_no_o;
        else if (be_no_o !== hold_be) hold_bad++;
        w--;
        rdy_ni = 1'b1; brdy_ni = 1'b1;
      end else begin
        if (nbeats < 8) begin
          ob_be[nbeats] = be_no_o; ob_ad[nbeats] = addr_o; ob_bl[nbeats] = blast_no_o;
        end
        nbeats++;
        rdy_ni = use_rdy ? 1'b0 : 1'b1;
        brdy_ni = use_rdy ? 1'b1 : 1'b0;
      end
      @(negedge clk_i);
    end
    req_i = 1'b0; rdy_ni = 1'b1; brdy_ni = 1'b1;
    chk(done_o === 1'b1, "R9 done after final ready", 32'(done_o), 32'd1);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R9 done single clock", 32'(done_o), 32'd0);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ads_no === 1'b1 && blast_no_o === 1'b1, "R10 strobe/flag idle", {ads_no, blast_no_o}, 2'b11);
    chk(be_no_o === 4'hF, "R10 enables idle", be_no_o, 4'hF);
    chk(done_o === 1'b0 && ack_o === 1'b0, "R10 done/ack low", {done_o, ack_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NVEC; v++) begin
      run_xfer(BASE | 32'(VEC[v].nib), VEC[v].len, 2'(v % 3), VEC[v].use_rdy, 0, 0);
      chk(first_ack == 1, "R8 ack when idle", first_ack, 1);
      chk(nbeats == int'(VEC[v].nb), "R1 R3 beat count", nbeats, VEC[v].nb);
      chk(nads == int'(VEC[v].na), "R6 R7 strobe count", nads, VEC[v].na);
      chk(qual_bad == 0, "R4 qualifiers", qual_bad, 0);
      chk(ob_be[0] === VEC[v].be0, "R2 R3 first enables", ob_be[0], VEC[v].be0);
      chk(ob_ad[0] === (BASE | 32'(VEC[v].a0)), "R2 R3 first address", ob_ad[0], BASE | 32'(VEC[v].a0));
      chk(ob_bl[0] === VEC[v].bl0, "R1 R3 first last-flag", ob_bl[0], VEC[v].bl0);
      if (VEC[v].nb == 3'd2) begin
        chk(ob_be[1] === VEC[v].be1, "R2 R7 second enables", ob_be[1], VEC[v].be1);
        chk(ob_ad[1] === (BASE | 32'(VEC[v].a1)), "R2 R4 second address", ob_ad[1], BASE | 32'(VEC[v].a1));
        chk(ob_bl[1] === VEC[v].bl1, "R1 R7 second last-flag", ob_bl[1], VEC[v].bl1);
      end
    end

    // R5: three pieces, offset 3, six bytes
    run_xfer(BASE | 32'h3, 4'd6, 2'd2, 1'b0, 0, 0);
    chk(nads == 3 && nbeats == 4, "R5 piece strobes/beats", {nads[15:0], nbeats[15:0]}, {16'd3, 16'd4});
    chk(ob_be[0] === 4'b0111 && ob_ad[0] === (BASE | 32'h3), "R5 piece0", {ob_be[0], ob_ad[0][3:0]}, 8'h73);
    chk(ob_be[1] === 4'b0000 && ob_ad[1] === (BASE | 32'h4) && ob_bl[1] === 1'b1, "R5 piece1", {ob_be[1], ob_ad[1][3:0]}, 8'h04);
    chk(ob_be[3] === 4'b1110 && ob_ad[3] === (BASE | 32'h8) && ob_bl[3] === 1'b0, "R5 piece2", {ob_be[3], ob_ad[3][3:0]}, 8'hE8);

    // R5: carry across a 16-byte boundary
    run_xfer(32'h0000_7FFE, 4'd4, 2'd1, 1'b0, 0, 0);
    chk(nads == 2 && nbeats == 2, "R5 carry counts", {nads[15:0], nbeats[15:0]}, {16'd2, 16'd2});
    chk(ob_ad[0] === 32'h0000_7FFE && ob_be[0] === 4'b0011, "R5 carry first", ob_ad[0], 32'h7FFE);
    chk(ob_ad[1] === 32'h0000_8000 && ob_be[1] === 4'b1100, "R5 carry second", ob_ad[1], 32'h8000);

    // R6: wait states on the first beat
    run_xfer(BASE, 4'd4, 2'd0, 1'b0, 3, 0);
    chk(hold_bad == 0, "R6 enables hold in wait", hold_bad, 0);
    chk(nads == 1 && nbeats == 2, "R6 no strobe in wait", {nads[15:0], nbeats[15:0]}, {16'd1, 16'd2});

    // R8: request held during a running transfer
    run_xfer(BASE | 32'h1, 4'd3, 2'd0, 1'b0, 0, 1);
    chk(busy_ack == 0, "R8 no ack while busy", busy_ack, 0);
    chk(nads == 1 && ob_be[1] === 4'b0011, "R8 transfer unchanged", {nads[15:0], 12'h0, ob_be[1]}, {16'd1, 16'h3});

    // R9: zero length
    @(negedge clk_i);
    addr_i = BASE; len_i = 4'd0; req_i = 1'b1;
    #1 chk(ack_o === 1'b1, "R9 zero-length ack", ack_o, 1);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(done_o === 1'b1 && ads_no === 1'b1, "R9 zero-length done", {done_o, ads_no}, 2'b11);
    @(negedge clk_i);
    chk(done_o === 1'b0 && ads_no === 1'b1, "R9 zero-length quiet", {done_o, ads_no}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule